// File: doc/BRIEF.md
# One-wire slave identity command stage

This block is the identity stage of a single-wire bus slave. A bit-level front end below it reports three kinds of single-cycle event: a bus reset with presence, a bit written by the master, and a read slot in which the slave may pull the line low. After each bus reset the block collects an 8-bit command, least significant bit first. It then runs one of four identity exchanges against a fixed 64-bit identity.

The identity is formed from three parameters: a family byte in bits 7:0, a serial number in bits 55:8 and a check byte in bits 63:56. It is transmitted from bit 0 upward. When an exchange ends successfully, a select output rises and stays high until the next bus reset, which hands the bus to the memory-command stage above. A constant CRC-8 checker reports whether the stored check byte is consistent with the rest of the identity.

Top module: `owc_rom_layer`

## Requirements
- R1: After `rst_n` deasserts, the block ignores written bits and read slots until the first `bus_rst`: `func_sel` stays 0 and `line_pull` stays 0.
- R2: After `bus_rst`, the next 8 written bits form the command, with the first bit as bit 0. The command codes are 8'h33 to read the identity, 8'h55 to match it, 8'hF0 to search, and 8'hCC to skip.
- R3: Read command: each of the next 64 read slots returns identity bit k (k = 0..63). `line_pull` is high during the slot exactly when the bit is 0. `func_sel` rises after the 64th slot.
- R4: Match command: when 64 written bits all equal identity bits 0..63, `func_sel` rises in the cycle after the 64th bit.
- R5: Match command: on the first written bit that differs, the block goes idle. `func_sel` stays 0 and read slots leave the line released until `bus_rst`.
- R6: Search command: for each bit k the block answers two read slots, first with bit k and then with its complement. It then takes a written bit. If all 64 written bits equal the identity, `func_sel` rises.
- R7: Search command: a written bit that differs from identity bit k makes the block drop out. No later read slot pulls the line, and `func_sel` stays 0 until `bus_rst`.
- R8: Skip command: `func_sel` rises right after the 8th command bit, with no identity exchange.
- R9: Any other command code leaves the block idle until `bus_rst`. Further written bits do not form a new command.
- R10: `bus_rst` aborts any exchange, drops `func_sel` in the following cycle and restarts command reception. It wins over a strobe in the same cycle.
- R11: `id_crc_ok` is 1 exactly when shifting all 64 identity bits, from bit 0 upward, through a CRC-8 (x^8+x^5+x^4+1, reflected form 8'h8C, start value 0) leaves zero.
- R12: `line_pull` is asserted only during a read slot in which a 0 is being sent. A write strobe never pulls the line and never advances a read or search sequence. A strobe of the wrong kind for the current step is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rst | input | 1 | Bus reset/presence event strobe |
| wr_stb | input | 1 | Master wrote a bit this cycle |
| wr_bit | input | 1 | Value of the written bit |
| rd_stb | input | 1 | Read slot open this cycle |
| line_pull | output | 1 | Drive-low enable for the open-drain line |
| func_sel | output | 1 | Memory-command stage selected |
| id_crc_ok | output | 1 | Identity check byte is consistent |

## Verification
The properties assume that the front end never raises `wr_stb` and `rd_stb` in the same cycle, and that each strobe lasts a single cycle. A `bus_rst` may coincide with either strobe. The stimulus tasks open exactly one kind of slot per call and clear it one cycle later. Bus resets are issued only through their own task, so every driven pattern stays inside these assumptions while still reaching every command, mismatch point and mid-exchange abort.

// File: rtl/owc_pkg.sv
package owc_pkg;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_CMD,
      ST_READ,
      ST_MATCH,
      ST_SRCH,
      ST_SEL
   } rom_st_e;

   localparam logic [7:0] CMD_READ  = 8'h33;
   localparam logic [7:0] CMD_MATCH = 8'h55;
   localparam logic [7:0] CMD_SRCH  = 8'hF0;
   localparam logic [7:0] CMD_SKIP  = 8'hCC;

   localparam logic [7:0] CRC8_REFL = 8'h8C;

   // serial CRC-8 over the low n bits, bit 0 first
   function automatic logic [7:0] crc8_bits(input logic [63:0] d, input int n);
      logic [7:0] c;
      logic fb;
      c = '0;
      for (int i = 0; i < n; i++) begin
         fb = c[0] ^ d[i];
         c  = {1'b0, c[7:1]} ^ (fb ? CRC8_REFL : 8'h00);
      end
      return c;
   endfunction

endpackage

// File: rtl/owc_slot_ctr.sv
module owc_slot_ctr #(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             adv,
   input  logic             tri_mode,
   output logic [IDX_W-1:0] idx,
   output logic [1:0]       phase
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx   <= '0;
         phase <= '0;
      end else if (clr) begin
         idx   <= '0;
         phase <= '0;
      end else if (adv) begin
         if (tri_mode && phase != 2'd2) begin
            phase <= phase + 2'd1;
         end else begin
            phase <= '0;
            idx   <= idx + 1'b1;
         end
      end
   end

endmodule

// File: rtl/owc_idchk.sv
module owc_idchk #(
   parameter int ID_W = 64
) (
   input  logic [ID_W-1:0] id,
   output logic            ok
);
   import owc_pkg::*;

   logic [7:0] acc [ID_W+1];

   assign acc[0] = '0;

   for (genvar g = 0; g < ID_W; g++) begin : g_stage
      logic fb;
      assign fb         = acc[g][0] ^ id[g];
      assign acc[g + 1] = {1'b0, acc[g][7:1]} ^ (fb ? CRC8_REFL : 8'h00);
   end

   assign ok = (acc[ID_W] == 8'h00);

endmodule

// File: rtl/owc_rom_layer.sv
module owc_rom_layer #(
   parameter int              SERIAL_W    = 48,
   parameter logic [7:0]      FAMILY_CODE = 8'h3C,
   parameter logic [SERIAL_W-1:0] SERIAL_NUM = SERIAL_W'(48'h0000_1A2B_3C4D),
   parameter logic [7:0]      CRC_BYTE    =
      owc_pkg::crc8_bits(64'({SERIAL_NUM, FAMILY_CODE}), 8 + SERIAL_W)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bus_rst,
   input  logic wr_stb,
   input  logic wr_bit,
   input  logic rd_stb,
   output logic line_pull,
   output logic func_sel,
   output logic id_crc_ok
);
   import owc_pkg::*;

   localparam int ID_W  = 16 + SERIAL_W;
   localparam int IDX_W = $clog2(ID_W);
   localparam logic [ID_W-1:0]  ROM_ID   = {CRC_BYTE, SERIAL_NUM, FAMILY_CODE};
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(ID_W - 1);
   localparam logic [IDX_W-1:0] CMD_LAST = IDX_W'(7);

   if (SERIAL_W % 8 != 0 || SERIAL_W < 8 || SERIAL_W > 48) begin : g_bad_serial
      $error("owc_rom_layer: SERIAL_W must be a multiple of 8 in 8..48");
   end

   rom_st_e          st_q;
   logic [7:0]       cmd_q;
   logic [7:0]       cmd_full;
   logic [IDX_W-1:0] idx;
   logic [1:0]       phase;
   logic             cur_bit;
   logic             id_last;
   logic             cmd_last;
   logic             ctr_clr;
   logic             ctr_adv;
   logic             tx_en;
   logic             tx_val;

   assign cur_bit  = ROM_ID[idx];
   assign id_last  = (idx == IDX_LAST);
   assign cmd_last = (idx == CMD_LAST);
   assign cmd_full = {wr_bit, cmd_q[7:1]};

   always_comb begin
      ctr_adv = 1'b0;
      unique case (st_q)
         ST_CMD:   ctr_adv = wr_stb;
         ST_READ:  ctr_adv = rd_stb;
         ST_MATCH: ctr_adv = wr_stb;
         ST_SRCH:  ctr_adv = (phase != 2'd2) ? rd_stb : wr_stb;
         default:  ctr_adv = 1'b0;
      endcase
   end

   assign ctr_clr = bus_rst || (st_q == ST_CMD && wr_stb && cmd_last);

   owc_slot_ctr #(.IDX_W(IDX_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (ctr_clr),
      .adv      (ctr_adv),
      .tri_mode (st_q == ST_SRCH),
      .idx      (idx),
      .phase    (phase)
   );

   always_comb begin
      tx_en  = 1'b0;
      tx_val = 1'b1;
      if (st_q == ST_READ) begin
         tx_en  = 1'b1;
         tx_val = cur_bit;
      end else if (st_q == ST_SRCH && phase != 2'd2) begin
         tx_en  = 1'b1;
         tx_val = (phase == 2'd0) ? cur_bit : ~cur_bit;
      end
   end

   assign line_pull = rd_stb && tx_en && !tx_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_WAIT;
         cmd_q <= '0;
      end else if (bus_rst) begin
         st_q  <= ST_CMD;
         cmd_q <= '0;
      end else begin
         unique case (st_q)
            ST_CMD: if (wr_stb) begin
               cmd_q <= cmd_full;
               if (cmd_last) begin
                  unique case (cmd_full)
                     CMD_READ:  st_q <= ST_READ;
                     CMD_MATCH: st_q <= ST_MATCH;
                     CMD_SRCH:  st_q <= ST_SRCH;
                     CMD_SKIP:  st_q <= ST_SEL;
                     default:   st_q <= ST_WAIT;
                  endcase
               end
            end
            ST_READ: if (rd_stb && id_last) st_q <= ST_SEL;
            ST_MATCH: if (wr_stb) begin
               if (wr_bit != cur_bit) st_q <= ST_WAIT;
               else if (id_last)      st_q <= ST_SEL;
            end
            ST_SRCH: if (phase == 2'd2 && wr_stb) begin
               if (wr_bit != cur_bit) st_q <= ST_WAIT;
               else if (id_last)      st_q <= ST_SEL;
            end
            default: st_q <= st_q;
         endcase
      end
   end

   assign func_sel = (st_q == ST_SEL);

   owc_idchk #(.ID_W(ID_W)) u_idchk (
      .id (ROM_ID),
      .ok (id_crc_ok)
   );

endmodule

// File: rtl/owc_rom_layer_chk.sv
module owc_rom_layer_chk (
   input logic clk,
   input logic rst_n,
   input logic bus_rst,
   input logic wr_stb,
   input logic rd_stb,
   input logic line_pull,
   input logic func_sel
);

   p_pull_in_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      line_pull |-> rd_stb);

   p_sel_after_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(func_sel) |-> $past(wr_stb || rd_stb) && !$past(bus_rst));

   p_busrst_desel_r10: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rst |=> !func_sel);

   p_sel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      func_sel |-> !line_pull);

   p_sel_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
      func_sel && !bus_rst |=> func_sel);

endmodule

bind owc_rom_layer owc_rom_layer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_rst   (bus_rst),
   .wr_stb    (wr_stb),
   .rd_stb    (rd_stb),
   .line_pull (line_pull),
   .func_sel  (func_sel)
);

// File: tb/owc_rom_layer_tb_top.sv
module owc_rom_layer_tb_top;

   localparam logic [7:0]  FAM = 8'h3C;
   localparam logic [47:0] SER = 48'h0000_1A2B_3C4D;

   function automatic logic [7:0] ref_crc(input logic [55:0] d);
      logic [7:0] c;
      logic fb;
      c = 8'h00;
      for (int i = 0; i < 56; i++) begin
         fb = c[0] ^ d[i];
         c  = {1'b0, c[7:1]};
         if (fb) c = c ^ 8'h8C;
      end
      return c;
   endfunction

   localparam logic [7:0]  GOOD_CRC = ref_crc({SER, FAM});
   localparam logic [63:0] ID       = {GOOD_CRC, SER, FAM};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_rst = 1'b0, wr_stb = 1'b0, wr_bit = 1'b0, rd_stb = 1'b0;
   logic line_pull, func_sel, id_crc_ok;
   logic bad_pull, bad_sel, bad_ok;

   always #4 clk = ~clk;

   owc_rom_layer #(.SERIAL_W(48), .FAMILY_CODE(FAM), .SERIAL_NUM(SER)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_stb(wr_stb), .wr_bit(wr_bit),
      .rd_stb(rd_stb), .line_pull(line_pull), .func_sel(func_sel), .id_crc_ok(id_crc_ok));

   owc_rom_layer #(.SERIAL_W(48), .FAMILY_CODE(FAM), .SERIAL_NUM(SER),
                   .CRC_BYTE(GOOD_CRC ^ 8'h01)) dut_bad (
      .clk(clk), .rst_n(rst_n), .bus_rst(bus_rst), .wr_stb(wr_stb), .wr_bit(wr_bit),
      .rd_stb(rd_stb), .line_pull(bad_pull), .func_sel(bad_sel), .id_crc_ok(bad_ok));

   int total = 0;
   int bad = 0;
   bit finished = 0;

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b @%0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: 0 wait, 1 cmd, 2 read, 3 match, 4 search, 5 selected
   int ms = 0, mi = 0, mp = 0;
   logic [7:0] mc = 8'h00;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ms = 0; mi = 0; mp = 0; mc = 8'h00;
      end else if (bus_rst) begin
         ms = 1; mi = 0; mp = 0;
      end else begin
         case (ms)
            1: if (wr_stb) begin
               mc = {wr_bit, mc[7:1]};
               mi++;
               if (mi == 8) begin
                  mi = 0;
                  if (mc == 8'h33) ms = 2;
                  else if (mc == 8'h55) ms = 3;
                  else if (mc == 8'hF0) ms = 4;
                  else if (mc == 8'hCC) ms = 5;
                  else ms = 0;
               end
            end
            2: if (rd_stb) begin
               mi++;
               if (mi == 64) ms = 5;
            end
            3: if (wr_stb) begin
               if (wr_bit != ID[mi]) ms = 0;
               else begin mi++; if (mi == 64) ms = 5; end
            end
            4: begin
               if (mp < 2) begin
                  if (rd_stb) mp++;
               end else if (wr_stb) begin
                  if (wr_bit != ID[mi]) ms = 0;
                  else begin mp = 0; mi++; if (mi == 64) ms = 5; end
               end
            end
            default: ;
         endcase
      end
   end

   function automatic logic m_pull();
      if (!rd_stb) return 1'b0;
      if (ms == 2) return !ID[mi];
      if (ms == 4 && mp == 0) return !ID[mi];
      if (ms == 4 && mp == 1) return ID[mi];
      return 1'b0;
   endfunction

   always @(negedge clk) begin
      #3;
      if (rst_n && !finished) begin
         chk("R12 per-cycle line_pull", line_pull, m_pull());
         chk("R10 per-cycle func_sel", func_sel, logic'(ms == 5));
      end
   end

   task automatic rd_slot(output logic pl);
      @(negedge clk);
      rd_stb = 1'b1;
      #3 pl = line_pull;
      @(posedge clk);
      #1 rd_stb = 1'b0;
   endtask

   task automatic wr_slot(input logic b);
      @(negedge clk);
      wr_stb = 1'b1;
      wr_bit = b;
      @(posedge clk);
      #1 wr_stb = 1'b0;
   endtask

   task automatic brst();
      @(negedge clk);
      bus_rst = 1'b1;
      @(posedge clk);
      #1 bus_rst = 1'b0;
   endtask

   task automatic send_cmd(input logic [7:0] c);
      for (int i = 0; i < 8; i++) wr_slot(c[i]);
   endtask

   task automatic settle();
      @(negedge clk);
      #3;
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      #(8 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic p;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      settle();
      chk("R1 reset func_sel", func_sel, 1'b0);
      chk("R11 good check byte", id_crc_ok, 1'b1);
      chk("R11 bad check byte", bad_ok, 1'b0);

      // R1: command without a prior bus reset is ignored
      send_cmd(8'hCC);
      rd_slot(p);
      chk("R1 no pull before bus reset", p, 1'b0);
      settle();
      chk("R1 no select before bus reset", func_sel, 1'b0);

      // R2/R3/R12: read identity, with a stray write slot in the middle
      brst();
      send_cmd(8'h33);
      for (int k = 0; k < 5; k++) begin
         rd_slot(p);
         chk("R3 read bit", p, !ID[k]);
      end
      wr_slot(1'b0);
      for (int k = 5; k < 64; k++) begin
         rd_slot(p);
         chk("R12 read bit after write slot", p, !ID[k]);
         if (k == 62) chk("R3 not selected early", func_sel, 1'b0);
      end
      settle();
      chk("R3 selected after 64 reads", func_sel, 1'b1);

      // R10: bus reset drops select
      brst();
      settle();
      chk("R10 deselect on bus reset", func_sel, 1'b0);

      // R8: skip
      send_cmd(8'hCC);
      settle();
      chk("R8 skip selects", func_sel, 1'b1);
      rd_slot(p);
      chk("R8 selected leaves line", p, 1'b0);

      // R4: full match
      brst();
      send_cmd(8'h55);
      for (int k = 0; k < 64; k++) wr_slot(ID[k]);
      settle();
      chk("R4 match selects", func_sel, 1'b1);

      // R5: mismatch at bit 20
      brst();
      send_cmd(8'h55);
      for (int k = 0; k < 64; k++) wr_slot(k == 20 ? !ID[k] : ID[k]);
      settle();
      chk("R5 mismatch no select", func_sel, 1'b0);
      rd_slot(p);
      chk("R5 idle no pull", p, 1'b0);

      // R6: full search
      brst();
      send_cmd(8'hF0);
      for (int k = 0; k < 64; k++) begin
         logic a;
         logic b;
         rd_slot(a);
         rd_slot(b);
         chk("R6 search true bit", a, !ID[k]);
         chk("R6 search complement", b, ID[k]);
         wr_slot(ID[k]);
      end
      settle();
      chk("R6 search selects", func_sel, 1'b1);

      // R7: search drop-out at bit 5 (bit 6 is 0 and would pull)
      brst();
      send_cmd(8'hF0);
      for (int k = 0; k < 5; k++) begin
         rd_slot(p);
         rd_slot(p);
         wr_slot(ID[k]);
      end
      rd_slot(p);
      rd_slot(p);
      wr_slot(!ID[5]);
      rd_slot(p);
      chk("R7 dropped out first slot", p, 1'b0);
      rd_slot(p);
      chk("R7 dropped out second slot", p, 1'b0);
      settle();
      chk("R7 no select", func_sel, 1'b0);

      // R9: unknown code, then a valid code without bus reset
      brst();
      send_cmd(8'h5A);
      send_cmd(8'hCC);
      settle();
      chk("R9 unknown stays idle", func_sel, 1'b0);

      // R10: abort mid read, then skip
      brst();
      send_cmd(8'h33);
      for (int k = 0; k < 10; k++) rd_slot(p);
      brst();
      send_cmd(8'hCC);
      settle();
      chk("R10 restart after abort", func_sel, 1'b1);

      // R2: command bit order (reversed skip code 0x33 is read, not skip)
      brst();
      send_cmd(8'h33);
      settle();
      chk("R2 bit order read not skip", func_sel, 1'b0);
      rd_slot(p);
      chk("R2 read bit 0 after code", p, !ID[0]);

      repeat (4) @(posedge clk);
      summary();
   end

endmodule